// File: doc/BRIEF.md
# Temperature Sensor Channel Switch Sequencer

This block owns the control and status words of a temperature sensor with one on-die channel and several remote channels. A requester asks for a logical channel over a request/acknowledge pair. The block then drives the control word through a fixed order. It first halts conversion, then loads the new source selection, and then resumes conversion. The acknowledgement is held back until the sample-valid flag has come back up after a programmable conversion latency.

Samples come from the analog front end on a sample port. The block filters them through a power-of-two averaging window, or passes them straight through when averaging is bypassed. The result is kept in the status word. Software reaches both control words and the status word through a small register port with a registered read. Turning samples into degrees is left to the consumer.

Top module: `tsen_chan_seq`

## Requirements
- R1: After reset, control word 0 reads 0x03000005 (run bit 0 set, enable bit 2 set, oversampling field bits 25:24 = 3, source-mode bits 31:30 = 0). Control word 1 reads 0x00000001, the status word reads 0 and acknowledge is low.
- R2: Logical channel 0 sets source mode 0 and source index (bits 16:13) 0. Logical channel n from 1 to 4 sets source mode 2 and source index n-1.
- R3: A change to a different legal channel proceeds as follows. The run bit stays 1 in the cycle after the request. It is 0 after the second edge, with mode and index still old. It is 0 after the third edge, with mode and index new. It is 1 again after the fourth edge.
- R4: The valid flag (status bit 16) falls on the edge that clears the run bit. It rises exactly LAT_CYC cycles after the edge that sets the run bit again. After reset it rises LAT_CYC cycles after reset is released.
- R5: For a change, acknowledge pulses for one cycle, one edge after the valid flag rises, with the error flag low.
- R6: A request for the channel already selected is acknowledged without error on the next edge and leaves control word 0 unchanged.
- R7: A request for a channel above 4 is acknowledged with the error flag on the next edge and leaves control word 0 unchanged.
- R8: With averaging enabled (control word 0 bit 6 clear), the temperature field (status bits 9:0) takes floor(sum/2^N) of each run of 2^N accepted samples, where N is control word 1 bits 2:0. Any write to either control word restarts the window.
- R9: With control word 0 bit 6 set, every accepted sample goes straight to the temperature field.
- R10: Samples offered while the run bit is 0 are discarded and leave the temperature field unchanged.
- R11: Writes to the status address (2) are ignored. Reads of addresses 0, 1 and 2 return the words one edge after the address is presented. Address 3 reads 0.
- R12: A request that arrives while a change is in progress is ignored. It produces no acknowledgement and no change to control word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control 0, 1 control 1, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| chg_req | input | 1 | Channel change request, one-cycle pulse |
| chg_chan | input | CH_W | Requested logical channel |
| chg_ack | output | 1 | Request completed, one-cycle pulse |
| chg_err | output | 1 | Request rejected, valid with chg_ack |
| smp_vld | input | 1 | Front-end sample strobe |
| smp_data | input | TEMP_W | Front-end raw sample |
| ctrl0_o | output | 32 | Control word 0 to the front end |
| ctrl1_o | output | 32 | Control word 1 to the front end |

## Verification
Take the request edge as E0. An illegal or same-channel request answers after E0. A real change clears the run bit after E1, swaps the selection after E2, restarts after E3, raises valid after E3+LAT_CYC and acknowledges after E4+LAT_CYC. The bench drives on falling edges and checks every one of these cycles, including those where nothing may happen yet. Reads are registered, so an observed status value reflects the word one edge earlier, and each expected valid and temperature value is shifted by that edge. An averaged result appears on the edge of the last sample in its window and is read back two edges later.

// File: rtl/tsen_pkg.sv
package tsen_pkg;
  localparam int C0_START   = 0;
  localparam int C0_RESET   = 1;
  localparam int C0_ENABLE  = 2;
  localparam int C0_AVG_BYP = 6;
  localparam int C0_IDX_LSB = 13;
  localparam int IDX_W      = 4;
  localparam int C0_OSR_LSB = 24;
  localparam int C0_MODE_LSB = 30;
  localparam int MODE_W     = 2;
  localparam int C1_AVG_W   = 3;
  localparam int ST_VALID   = 16;

  localparam logic [MODE_W-1:0] MODE_INT = 2'd0;
  localparam logic [MODE_W-1:0] MODE_EXT = 2'd2;

  localparam logic [31:0] C0_RST = (32'h3 << C0_OSR_LSB) | (32'h1 << C0_ENABLE)
                                 | (32'h1 << C0_START);
  localparam logic [31:0] C1_RST = 32'h1;

  typedef enum logic [2:0] {SQ_IDLE, SQ_STOP, SQ_PROG, SQ_GO, SQ_WAIT} sq_state_t;

  typedef struct packed {
    logic              stop;
    logic              prog;
    logic              go;
    logic [MODE_W-1:0] mode;
    logic [IDX_W-1:0]  idx;
  } seq_op_t;
endpackage

// File: rtl/tsen_ctrl_regs.sv
module tsen_ctrl_regs
  import tsen_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  input  seq_op_t     op,
  output logic [31:0] c0,
  output logic [31:0] c1,
  output logic        cfg_wr
);
  assign cfg_wr = we && (addr == 2'd0 || addr == 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      c0 <= C0_RST;
      c1 <= C1_RST;
    end else begin
      if (we && addr == 2'd0) c0 <= wdata;
      if (we && addr == 2'd1) c1 <= wdata;
      // sequencer steps take priority over software
      if (op.stop) c0[C0_START] <= 1'b0;
      if (op.prog) begin
        c0[C0_MODE_LSB +: MODE_W] <= op.mode;
        c0[C0_IDX_LSB +: IDX_W]   <= op.idx;
      end
      if (op.go) c0[C0_START] <= 1'b1;
    end
  end
endmodule

// File: rtl/tsen_chan_fsm.sv
module tsen_chan_fsm
  import tsen_pkg::*;
#(
  parameter int NEXT = 4,
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req,
  input  logic [CH_W-1:0] chan,
  input  logic            valid,
  output seq_op_t         op,
  output logic            ack,
  output logic            err
);
  sq_state_t       st;
  logic [CH_W-1:0] cur;
  logic [CH_W-1:0] tgt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= SQ_IDLE;
      cur <= '0;
      tgt <= '0;
      ack <= 1'b0;
      err <= 1'b0;
    end else begin
      ack <= 1'b0;
      err <= 1'b0;
      case (st)
        SQ_IDLE: if (req && !ack) begin
          if (chan > CH_W'(NEXT)) begin
            ack <= 1'b1;
            err <= 1'b1;
          end else if (chan == cur) begin
            ack <= 1'b1;
          end else begin
            tgt <= chan;
            st  <= SQ_STOP;
          end
        end
        SQ_STOP: st <= SQ_PROG;
        SQ_PROG: begin
          cur <= tgt;
          st  <= SQ_GO;
        end
        SQ_GO:   st <= SQ_WAIT;
        SQ_WAIT: if (valid) begin
          ack <= 1'b1;
          st  <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    op.stop = (st == SQ_STOP);
    op.prog = (st == SQ_PROG);
    op.go   = (st == SQ_GO);
    op.mode = (tgt == '0) ? MODE_INT : MODE_EXT;
    op.idx  = (tgt == '0) ? '0 : IDX_W'(tgt - CH_W'(1));
  end
endmodule

// File: rtl/tsen_conv_timer.sv
module tsen_conv_timer #(
  parameter int LAT = 1875000
) (
  input  logic clk,
  input  logic rst,
  input  logic stop,
  input  logic go,
  output logic valid
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt;
  logic          busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      busy  <= 1'b1;
      valid <= 1'b0;
    end else if (stop) begin
      cnt   <= '0;
      busy  <= 1'b0;
      valid <= 1'b0;
    end else if (go) begin
      cnt   <= '0;
      busy  <= 1'b1;
      valid <= 1'b0;
    end else if (busy) begin
      if (cnt == CW'(LAT - 1)) begin
        valid <= 1'b1;
        busy  <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsen_avg.sv
module tsen_avg #(
  parameter int TW   = 10,
  parameter int NMAX = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          run,
  input  logic          bypass,
  input  logic [2:0]    log2n,
  input  logic          smp_vld,
  input  logic [TW-1:0] smp,
  output logic [TW-1:0] temp
);
  localparam int AW = TW + NMAX;

  logic [2:0]    n_eff;
  logic [NMAX:0] span;
  logic [NMAX:0] cnt;
  logic [AW-1:0] acc;
  logic [AW-1:0] acc_n;
  logic          last;

  always_comb begin
    if (bypass)                n_eff = 3'd0;
    else if (log2n > 3'(NMAX)) n_eff = 3'(NMAX);
    else                       n_eff = log2n;
    span  = (NMAX+1)'(1) << n_eff;
    last  = (cnt == span - 1'b1);
    acc_n = acc + AW'(smp);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      cnt  <= '0;
      temp <= '0;
    end else if (clear) begin
      acc <= '0;
      cnt <= '0;
    end else if (run && smp_vld) begin
      if (last) begin
        temp <= TW'(acc_n >> n_eff);
        acc  <= '0;
        cnt  <= '0;
      end else begin
        acc <= acc_n;
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsen_chan_seq.sv
module tsen_chan_seq
  import tsen_pkg::*;
#(
  parameter int NEXT    = 4,
  parameter int CH_W    = 3,
  parameter int LAT_CYC = 1875000,
  parameter int TEMP_W  = 10,
  parameter int AVG_MAX = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              chg_req,
  input  logic [CH_W-1:0]   chg_chan,
  output logic              chg_ack,
  output logic              chg_err,
  input  logic              smp_vld,
  input  logic [TEMP_W-1:0] smp_data,
  output logic [31:0]       ctrl0_o,
  output logic [31:0]       ctrl1_o
);
  seq_op_t           op;
  logic              cfg_wr;
  logic              conv_valid;
  logic [TEMP_W-1:0] temp;
  logic [31:0]       status_w;
  logic              run;

  tsen_ctrl_regs u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .op(op), .c0(ctrl0_o), .c1(ctrl1_o), .cfg_wr(cfg_wr)
  );

  tsen_chan_fsm #(.NEXT(NEXT), .CH_W(CH_W)) u_fsm (
    .clk(clk), .rst(rst), .req(chg_req), .chan(chg_chan), .valid(conv_valid),
    .op(op), .ack(chg_ack), .err(chg_err)
  );

  tsen_conv_timer #(.LAT(LAT_CYC)) u_tmr (
    .clk(clk), .rst(rst), .stop(op.stop), .go(op.go), .valid(conv_valid)
  );

  assign run = ctrl0_o[C0_START] & ctrl0_o[C0_ENABLE] & ~ctrl0_o[C0_RESET];

  tsen_avg #(.TW(TEMP_W), .NMAX(AVG_MAX)) u_avg (
    .clk(clk), .rst(rst), .clear(cfg_wr | op.stop), .run(run),
    .bypass(ctrl0_o[C0_AVG_BYP]), .log2n(ctrl1_o[C1_AVG_W-1:0]),
    .smp_vld(smp_vld), .smp(smp_data), .temp(temp)
  );

  always_comb begin
    status_w               = '0;
    status_w[TEMP_W-1:0]   = temp;
    status_w[ST_VALID]     = conv_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        2'd0:    reg_rdata <= ctrl0_o;
        2'd1:    reg_rdata <= ctrl1_o;
        2'd2:    reg_rdata <= status_w;
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tsen_chan_seq_chk.sv
module tsen_chan_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_we,
  input logic [1:0] mode,
  input logic       start,
  input logic       ack,
  input logic       err,
  input logic       valid
);
  AST_MODE_WHILE_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!$past(reg_we) && mode != $past(mode)) |-> !start); // R3
  AST_VALID_FALL_STOPPED: assert property (@(posedge clk) disable iff (rst)
    $fell(valid) |-> !start); // R4
  AST_VALID_RISE_RUNNING: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> start); // R4
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R5
  AST_ERR_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
    err |-> ack); // R7
endmodule

bind tsen_chan_seq tsen_chan_seq_chk u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .mode(ctrl0_o[31:30]),
  .start(ctrl0_o[0]), .ack(chg_ack), .err(chg_err), .valid(conv_valid)
);

// File: tb/tsen_chan_seq_bench.sv
module tsen_chan_seq_bench;
  localparam int LAT = 12;
  localparam int NEXT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd2;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        chg_req = 1'b0;
  logic [2:0]  chg_chan = '0;
  logic        chg_ack, chg_err;
  logic        smp_vld = 1'b0;
  logic [9:0]  smp_data = '0;
  logic [31:0] ctrl0_o, ctrl1_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_c0;
  int cur = 0;

  always #4 clk = ~clk;

  tsen_chan_seq #(.NEXT(NEXT), .CH_W(3), .LAT_CYC(LAT), .TEMP_W(10), .AVG_MAX(7))
    u_tsen_chan_seq (
      .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chg_req(chg_req),
      .chg_chan(chg_chan), .chg_ack(chg_ack), .chg_err(chg_err),
      .smp_vld(smp_vld), .smp_data(smp_data), .ctrl0_o(ctrl0_o), .ctrl1_o(ctrl1_o)
    );

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sel(logic [31:0] c, int ch);
    logic [31:0] r = c;
    r[31:30] = (ch == 0) ? 2'd0 : 2'd2;
    r[16:13] = (ch == 0) ? 4'd0 : 4'(ch - 1);
    return r;
  endfunction

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_addr = 2'd2;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = reg_rdata; reg_addr = 2'd2;
  endtask

  task automatic change(int ch, bit inject);
    @(negedge clk); reg_addr = 2'd2; chg_req = 1'b1; chg_chan = 3'(ch);
    @(negedge clk); chg_req = 1'b0;                       // after E0
    if (ch > NEXT) begin
      chk("R7", "ack", 32'(chg_ack), 32'd1);
      chk("R7", "err", 32'(chg_err), 32'd1);
      chk("R7", "ctrl0 kept", ctrl0_o, exp_c0);
      @(negedge clk);
      chk("R7", "ctrl0 kept later", ctrl0_o, exp_c0);
      return;
    end
    if (ch == cur) begin
      chk("R6", "ack", 32'(chg_ack), 32'd1);
      chk("R6", "err", 32'(chg_err), 32'd0);
      @(negedge clk);
      chk("R6", "ctrl0 kept", ctrl0_o, exp_c0);
      return;
    end
    chk("R3", "run still set after E0", ctrl0_o, exp_c0);
    if (inject) begin chg_req = 1'b1; chg_chan = 3'((ch == 1) ? 2 : 1); end
    @(negedge clk); chg_req = 1'b0;                       // after E1
    chk("R3", "stopped, old select", ctrl0_o, exp_c0 & ~32'h1);
    chk("R4", "valid before stop", 32'(reg_rdata[16]), 32'd1);
    @(negedge clk);                                       // after E2
    chk("R2", "new select while stopped", ctrl0_o, sel(exp_c0, ch) & ~32'h1);
    chk("R4", "valid dropped", 32'(reg_rdata[16]), 32'd0);
    @(negedge clk);                                       // after E3
    exp_c0 = sel(exp_c0, ch) | 32'h1;
    chk("R3", "restarted", ctrl0_o, exp_c0);
    for (int k = 4; k <= 4 + LAT; k++) begin
      @(negedge clk);
      chk("R4", "valid timing", 32'(reg_rdata[16]), 32'(k >= 4 + LAT));
      chk("R5", "ack timing", 32'(chg_ack), 32'(k == 4 + LAT));
    end
    chk("R5", "no error", 32'(chg_err), 32'd0);
    @(negedge clk);
    chk("R5", "ack single", 32'(chg_ack), 32'd0);
    if (inject) chk("R12", "late request ignored", ctrl0_o, exp_c0);
    cur = ch;
  endtask

  task automatic feed(logic [9:0] d);
    @(negedge clk); smp_vld = 1'b1; smp_data = d;
    @(negedge clk); smp_vld = 1'b0;
  endtask

  task automatic avg_run(int n, int base);
    logic [31:0] v;
    int sum = 0;
    int span = 1 << n;
    wr(2'd1, 32'(n));
    for (int i = 0; i < span; i++) begin
      logic [9:0] d = 10'((base + 37 * i) % 1024);
      sum += int'(d);
      if (i % 3 == 1) begin @(negedge clk); smp_vld = 1'b0; end
      @(negedge clk); smp_vld = 1'b1; smp_data = d;
    end
    @(negedge clk); smp_vld = 1'b0;
    rd(2'd2, v);
    chk("R8", $sformatf("average N=%0d", n), 32'(v[9:0]), 32'(sum >> n));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] st;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "ctrl0", ctrl0_o, 32'h0300_0005);
    chk("R1", "ctrl1", ctrl1_o, 32'h1);
    chk("R1", "ack", 32'(chg_ack), 32'd0);
    chk("R1", "status", reg_rdata, 32'd0);
    exp_c0 = 32'h0300_0005;
    repeat (LAT + 2) @(negedge clk);
    rd(2'd2, v);
    chk("R4", "valid after reset", 32'(v[16]), 32'd1);

    change(0, 0);
    change(1, 0);
    change(2, 0);
    change(2, 0);
    change(3, 0);
    change(4, 0);
    change(5, 0);
    change(6, 0);
    change(7, 0);
    change(0, 1);
    change(4, 1);

    // averaging sweep
    exp_c0[6] = 1'b0;
    wr(2'd0, exp_c0);
    avg_run(0, 100);
    avg_run(1, 201);
    avg_run(2, 333);
    avg_run(3, 517);
    avg_run(5, 611);

    // bypass with a deep window configured
    exp_c0[6] = 1'b1;
    wr(2'd0, exp_c0);
    wr(2'd1, 32'd3);
    for (int i = 0; i < 3; i++) begin
      feed(10'(700 + 45 * i));
      rd(2'd2, v);
      chk("R9", "bypass passes sample", 32'(v[9:0]), 32'(700 + 45 * i));
    end

    // samples discarded while halted
    rd(2'd2, st);
    wr(2'd0, exp_c0 & ~32'h1);
    for (int i = 0; i < 4; i++) feed(10'd999);
    rd(2'd2, v);
    chk("R10", "temp unchanged while halted", 32'(v[9:0]), 32'(st[9:0]));
    exp_c0[6] = 1'b0;
    wr(2'd0, exp_c0);
    wr(2'd1, 32'd1);
    feed(10'd10);
    feed(10'd21);
    rd(2'd2, v);
    chk("R10", "window restarts after resume", 32'(v[9:0]), 32'd15);

    // register port
    rd(2'd0, v);
    chk("R11", "read ctrl0", v, exp_c0);
    wr(2'd1, 32'hA5A5_0002);
    rd(2'd1, v);
    chk("R11", "read ctrl1", v, 32'hA5A5_0002);
    rd(2'd2, st);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v);
    chk("R11", "status write ignored", v, st);
    rd(2'd3, v);
    chk("R11", "unmapped reads zero", v, 32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule